// File: doc/BRIEF.md
# Supply Status Lamp and Alert Encoder

This block turns the condition flags of a power supply into what an operator sees and what a system controller hears. It takes five flags: input power present, standby rail up, main rail up and in regulation, a shutdown-class fault, and a warning-class event. From them it drives a green lamp and an amber lamp, each off, steadily on, or slowly blinking, and an active-low alert line.

The flags pass through a fixed priority. The highest-ranked condition that holds decides both lamps. A free-running divider makes one shared slow blink phase from the system clock: a 50% square wave whose period is a parameter, one second at the default clock. Every blinking lamp follows that phase. A change of condition never restarts it. All three outputs are registered, so they change one clock after the flags do.

Fault detection and any status readout over a management bus are done elsewhere. This block only encodes conditions that are already resolved.

Top module: `psu_status_indicator`

## Requirements
- R1: While `rst_n` is low, `led_green` and `led_amber` are 0 and `alert_n` is 1. The blink phase restarts at 0.
- R2: When `fault_shutdown` is 1, amber is steadily on and green is off, whatever the other flags are. This condition has the highest priority.
- R3: When `warn_event` is 1 and `fault_shutdown` is 0, green is off and amber follows the blink phase.
- R4: When `ac_present` is 0 and neither fault nor warning is set, both lamps are off, whatever `standby_on` and `main_ok` are.
- R5: When `ac_present` and `standby_on` are 1, `main_ok` is 0, and there is no fault or warning, green follows the blink phase and amber is off.
- R6: When `ac_present`, `standby_on` and `main_ok` are all 1 and there is no fault or warning, green is steadily on and amber is off.
- R7: When `ac_present` is 1, `standby_on` is 0, and there is no fault or warning, both lamps are off.
- R8: `alert_n` is 0 exactly when `fault_shutdown` or `warn_event` was 1 at the previous clock edge. Otherwise it is 1.
- R9: The blink phase is a square wave of period `BLINK_PERIOD_CYCLES`, low for the first half and high for the second. After the k-th rising edge since reset it equals floor(k / (BLINK_PERIOD_CYCLES/2)) mod 2.
- R10: The blink phase is free-running. When the condition changes, a blinking lamp takes up the phase where it stands and does not restart it.
- R11: Every output reflects the flags sampled at the previous rising edge (one cycle of latency). It holds its value between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also drives the blink divider |
| rst_n | input | 1 | Synchronous reset, active low |
| ac_present | input | 1 | Input power is present |
| standby_on | input | 1 | Standby rail is up |
| main_ok | input | 1 | Main rail is on and in regulation |
| fault_shutdown | input | 1 | A shutdown-class fault is active |
| warn_event | input | 1 | A warning-class event is active while operating |
| led_green | output | 1 | Green lamp drive, active high |
| led_amber | output | 1 | Amber lamp drive, active high |
| alert_n | output | 1 | Alert to the system controller, active low |

## Verification
Two things can land on the same clock edge: a change of condition and a toggle of the shared blink phase. If the design got this wrong, a lamp could restart its blink or take a one-cycle glitch. The bench walks a table of flag patterns. Each pattern lasts slightly longer than one blink period, so the changes move across every offset of the phase, including exactly on a toggle edge. One directed case also moves a blink from the green lamp to the amber lamp in the middle of a half-period. Each sample is compared with a phase model the bench keeps itself, counted in edges since reset, so a restarted or shifted blink shows up as a mismatch.

// File: rtl/psu_led_pkg.sv
package psu_led_pkg;

  typedef enum logic [2:0] {
    COND_DARK = 3'd0,
    COND_STBY = 3'd1,
    COND_OK   = 3'd2,
    COND_WARN = 3'd3,
    COND_FAIL = 3'd4
  } cond_e;

  typedef enum logic [1:0] {
    LAMP_OFF   = 2'd0,
    LAMP_ON    = 2'd1,
    LAMP_BLINK = 2'd2
  } lamp_e;

  localparam int NUM_LAMPS = 2;
  localparam int LAMP_GREEN = 0;
  localparam int LAMP_AMBER = 1;

  // Priority: fail, warn, no input power, standby only, fully on.
  function automatic cond_e resolve_cond(input logic ac, input logic sb,
                                         input logic mo, input logic fl,
                                         input logic wn);
    cond_e c;
    if (fl)             c = COND_FAIL;
    else if (wn)        c = COND_WARN;
    else if (!ac)       c = COND_DARK;
    else if (!sb)       c = COND_DARK;
    else if (!mo)       c = COND_STBY;
    else                c = COND_OK;
    return c;
  endfunction

  function automatic lamp_e green_mode(input cond_e c);
    case (c)
      COND_STBY: return LAMP_BLINK;
      COND_OK:   return LAMP_ON;
      default:   return LAMP_OFF;
    endcase
  endfunction

  function automatic lamp_e amber_mode(input cond_e c);
    case (c)
      COND_FAIL: return LAMP_ON;
      COND_WARN: return LAMP_BLINK;
      default:   return LAMP_OFF;
    endcase
  endfunction

  function automatic logic lamp_level(input lamp_e m, input logic phase);
    case (m)
      LAMP_ON:    return 1'b1;
      LAMP_BLINK: return phase;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic alert_level_n(input logic fl, input logic wn);
    return ~(fl | wn);
  endfunction

endpackage

// File: rtl/psu_led_blink_gen.sv
module psu_led_blink_gen #(
  parameter int HALF_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic blink_phase,
  output logic phase_flip
);
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign phase_flip = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      blink_phase <= 1'b0;
    end else if (phase_flip) begin
      cnt_q       <= '0;
      blink_phase <= ~blink_phase;
    end else begin
      cnt_q       <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/psu_led_cond_resolver.sv
module psu_led_cond_resolver
  import psu_led_pkg::*;
(
  input  logic  ac_present,
  input  logic  standby_on,
  input  logic  main_ok,
  input  logic  fault_shutdown,
  input  logic  warn_event,
  output cond_e cond,
  output lamp_e modes [NUM_LAMPS]
);
  always_comb begin
    cond = resolve_cond(ac_present, standby_on, main_ok,
                        fault_shutdown, warn_event);
    modes[LAMP_GREEN] = green_mode(cond);
    modes[LAMP_AMBER] = amber_mode(cond);
  end
endmodule

// File: rtl/psu_led_out_reg.sv
module psu_led_out_reg
  import psu_led_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lamp_e modes [NUM_LAMPS],
  input  logic  blink_phase,
  input  logic  alert_req_n,
  output logic  lamps [NUM_LAMPS],
  output logic  alert_n
);
  for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
    always_ff @(posedge clk) begin
      if (!rst_n) lamps[i] <= 1'b0;
      else        lamps[i] <= lamp_level(modes[i], blink_phase);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= alert_req_n;
  end
endmodule

// File: rtl/psu_status_indicator.sv
module psu_status_indicator
  import psu_led_pkg::*;
#(
  parameter int BLINK_PERIOD_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ac_present,
  input  logic standby_on,
  input  logic main_ok,
  input  logic fault_shutdown,
  input  logic warn_event,
  output logic led_green,
  output logic led_amber,
  output logic alert_n
);
  localparam int HALF_CYCLES = BLINK_PERIOD_CYCLES / 2;

  logic  blink_phase;
  logic  phase_flip;
  cond_e cur_cond;
  lamp_e lamp_modes [NUM_LAMPS];
  logic  lamp_out   [NUM_LAMPS];
  logic  alert_req_n;

  psu_led_blink_gen #(.HALF_CYCLES(HALF_CYCLES)) u_blink (
    .clk         (clk),
    .rst_n       (rst_n),
    .blink_phase (blink_phase),
    .phase_flip  (phase_flip)
  );

  psu_led_cond_resolver u_resolve (
    .ac_present     (ac_present),
    .standby_on     (standby_on),
    .main_ok        (main_ok),
    .fault_shutdown (fault_shutdown),
    .warn_event     (warn_event),
    .cond           (cur_cond),
    .modes          (lamp_modes)
  );

  assign alert_req_n = alert_level_n(fault_shutdown, warn_event);

  psu_led_out_reg u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .modes       (lamp_modes),
    .blink_phase (blink_phase),
    .alert_req_n (alert_req_n),
    .lamps       (lamp_out),
    .alert_n     (alert_n)
  );

  assign led_green = lamp_out[LAMP_GREEN];
  assign led_amber = lamp_out[LAMP_AMBER];
endmodule

// File: rtl/psu_status_indicator_chk.sv
module psu_status_indicator_chk
  import psu_led_pkg::*;
#(
  parameter int HALF_CYCLES = 50_000_000
) (
  input logic  clk,
  input logic  rst_n,
  input logic  fault_shutdown,
  input logic  warn_event,
  input logic  led_green,
  input logic  led_amber,
  input logic  alert_n,
  input logic  blink_phase,
  input logic  phase_flip,
  input cond_e cur_cond
);
  logic        prev_phase;
  logic [31:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_phase <= 1'b0;
      hold_cnt   <= '0;
    end else begin
      prev_phase <= blink_phase;
      hold_cnt   <= (blink_phase != prev_phase) ? 32'd0 : hold_cnt + 32'd1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!led_green && !led_amber && alert_n));

  // R2
  fail_amber_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_FAIL) |=> (led_amber && !led_green));

  // R3
  warn_amber_blink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_WARN) |=> (!led_green && led_amber == $past(blink_phase)));

  // R5
  stby_green_blink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_STBY) |=> (!led_amber && led_green == $past(blink_phase)));

  // R6
  ok_green_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_OK) |=> (led_green && !led_amber));

  // R4
  dark_lamps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cond == COND_DARK) |=> (!led_green && !led_amber));

  // R8
  alert_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_shutdown || warn_event) |=> !alert_n);

  // R8
  alert_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_shutdown && !warn_event) |=> alert_n);

  // R9
  phase_toggle_on_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_flip |=> (blink_phase != $past(blink_phase)));

  // R9
  phase_run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= 32'(HALF_CYCLES));
endmodule

bind psu_status_indicator psu_status_indicator_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fault_shutdown (fault_shutdown),
  .warn_event     (warn_event),
  .led_green      (led_green),
  .led_amber      (led_amber),
  .alert_n        (alert_n),
  .blink_phase    (blink_phase),
  .phase_flip     (phase_flip),
  .cur_cond       (cur_cond)
);

// File: tb/psu_status_indicator_tb.sv
module psu_status_indicator_tb;
  localparam int PERIOD = 16;
  localparam int HALF   = PERIOD / 2;
  localparam int NVEC   = 12;

  // Lamp mode codes in the table: 0 off, 1 steady, 2 blink.
  // Vector bits: [9] ac [8] sb [7] mo [6] fault [5] warn [4:3] green [2:1] amber [0] alert_n
  localparam logic [9:0] VEC [NVEC] = '{
    10'b00000_00_00_1, // R4 nothing present
    10'b11100_01_00_1, // R6 fully on
    10'b11000_10_00_1, // R5 standby only
    10'b10000_00_00_1, // R7 power but no standby
    10'b11110_00_01_0, // R2 fault while on
    10'b11101_00_10_0, // R3 warning while on
    10'b00010_00_01_0, // R2 fault outranks no power
    10'b00001_00_10_0, // R3 warning outranks no power
    10'b11011_00_01_0, // R2 fault outranks warning
    10'b01100_00_00_1, // R4 no power with rails claimed
    10'b11001_00_10_0, // R3 warning in standby
    10'b10100_00_00_1  // R7 main claimed without standby
  };
  localparam int VREQ [NVEC] = '{4, 6, 5, 7, 2, 3, 2, 3, 2, 4, 3, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ac_present = 1'b0, standby_on = 1'b0, main_ok = 1'b0;
  logic fault_shutdown = 1'b0, warn_event = 1'b0;
  logic led_green, led_amber, alert_n;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  psu_status_indicator #(.BLINK_PERIOD_CYCLES(PERIOD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ac_present(ac_present), .standby_on(standby_on),
    .main_ok(main_ok), .fault_shutdown(fault_shutdown), .warn_event(warn_event),
    .led_green(led_green), .led_amber(led_amber), .alert_n(alert_n)
  );

  function automatic logic model_phase(input int k);
    if (k < 1) return 1'b0;
    return logic'(((k - 1) / HALF) % 2);
  endfunction

  function automatic logic mode_level(input logic [1:0] m, input logic ph);
    if (m == 2'd1) return 1'b1;
    if (m == 2'd2) return ph;
    return 1'b0;
  endfunction

  task automatic check_bit(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b (edge %0d)", req, what, act, exp, edges);
    end
  endtask

  task automatic check_all(input int req, input logic [1:0] gm, input logic [1:0] am, input logic al);
    logic ph;
    ph = model_phase(edges);
    check_bit(req, "green", led_green, mode_level(gm, ph));
    check_bit(req, "amber", led_amber, mode_level(am, ph));
    check_bit(req, "alert_n", alert_n, al);
  endtask

  task automatic drive(input logic [4:0] f);
    {ac_present, standby_on, main_ok, fault_shutdown, warn_event} = f;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with flags that would otherwise light lamps
    drive(5'b11110);
    repeat (3) @(negedge clk);
    check_bit(1, "green in reset", led_green, 1'b0);
    check_bit(1, "amber in reset", led_amber, 1'b0);
    check_bit(1, "alert_n in reset", alert_n, 1'b1);
    drive(5'b00000);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: each pattern spans PERIOD+1 samples so change points slide over the phase
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][9:5]);
      for (int s = 0; s < PERIOD + 1; s++) begin
        @(negedge clk);
        check_all(VREQ[v], VEC[v][4:3], VEC[v][2:1], VEC[v][0]);
      end
    end

    // R9: green run length in standby equals half a period
    drive(5'b11000);
    begin
      logic last;
      int run;
      @(negedge clk);
      last = led_green;
      while (led_green == last) @(negedge clk);
      last = led_green;
      run = 0;
      while (led_green == last) begin
        @(negedge clk);
        run++;
      end
      checks++;
      if (run != HALF) begin
        errors++;
        $display("FAIL R9 blink half period: actual %0d expected %0d", run, HALF);
      end
    end

    // R10: move the blink from green to amber mid-run; phase must carry on
    drive(5'b11000);
    @(negedge clk);
    while (led_green !== 1'b0) @(negedge clk);
    while (led_green !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    drive(5'b11001);
    @(negedge clk);
    check_bit(10, "amber keeps running phase", led_amber, 1'b1);
    check_all(10, 2'd0, 2'd2, 1'b0);

    // R11: one cycle of latency, no change before the edge
    drive(5'b11100);
    repeat (2) @(negedge clk);
    drive(5'b11110);
    #1;
    check_bit(11, "green before edge", led_green, 1'b1);
    check_bit(11, "amber before edge", led_amber, 1'b0);
    check_bit(11, "alert_n before edge", alert_n, 1'b1);
    @(negedge clk);
    check_bit(11, "green after edge", led_green, 1'b0);
    check_bit(11, "amber after edge", led_amber, 1'b1);
    // R8: alert follows the fault
    check_bit(8, "alert_n with fault", alert_n, 1'b0);
    drive(5'b11100);
    @(negedge clk);
    check_bit(8, "alert_n released", alert_n, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule